// File: doc/BRIEF.md
# Predicated Byte-Merge Vector ALU

This block is a 128-bit vector execution unit for a processor's vector pipeline. On each accepted request it applies one operation to a pair of source vectors, or to a single source vector, and produces a new destination value. Bitwise operations, reversals and sign-bit operations act on the whole vector. Integer arithmetic, absolute value, negation and leading-bit counts act on each element, with elements 8, 16 or 32 bits wide.

The unit takes a 16-bit lane mask with one bit per byte of the vector. The computed result reaches the destination only in the enabled bytes. Every other byte keeps the old destination value, including bytes inside a wider element. The registered result appears one clock after the request. In that same cycle the unit raises a one-cycle strobe that tells the predication logic to step to its next state.

The sign-bit operations serve half- and single-precision data. They only clear or flip the top bit of each element and do no rounding or NaN handling. An opcode that is not defined, or an element-wise opcode paired with an unsupported size, still completes and still raises the strobe. In that case the destination is written back unchanged.

Top module: `vec_lane_alu`

## Requirements
- R1: A byte i of `dst_new` takes the computed result only when `lane_mask[i]` is 1. Otherwise it equals byte i of `dst_old` from the same request, even inside a 16- or 32-bit element.
- R2: Reset sets `dst_new` to zero and `advance` to 0. A request sampled with `in_valid` high at a rising edge updates `dst_new` and drives `advance` high for exactly the next cycle. With `in_valid` low, `dst_new` holds and `advance` is 0.
- R3: Opcodes 0 to 4 give a&b, a&~b, a|b, a|~b and a^b on all 128 bits. Opcode 22 gives ~a. These opcodes ignore `esize`.
- R4: Opcodes 5, 6 and 7 give per element a+b, a-b and the low half of a*b, wrapping modulo the element width. The element width is set by `esize`: 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits.
- R5: Opcode 8 gives the per-element absolute value of a, and the most negative value maps to itself. Opcode 9 gives the per-element two's complement negation.
- R6: Opcode 10 counts leading zeros of each element of a, giving the element width for zero. Opcode 11 counts the bits below the sign bit that equal it, excluding the sign bit itself, so an all-zero or all-one element gives width minus 1.
- R7: Opcodes 12 to 17 permute the bytes of a, ignoring `esize`. They are, in order: byte reverse in 16-bit containers, byte reverse in 32-bit containers, halfword swap in 32-bit containers, byte reverse in 64-bit containers, halfword reverse in 64-bit containers and word swap in 64-bit containers.
- R8: Opcodes 18 and 19 clear bit 15 of each halfword and bit 31 of each word of a, respectively. Opcodes 20 and 21 invert those same bits. No other bit changes.
- R9: Opcodes 23 to 31 are illegal, and so are opcodes 5 to 11 with `esize` equal to 3. An illegal request leaves `dst_new` equal to `dst_old` in every byte and still pulses `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| esize | input | 2 | Element size: 0 for 8 bits, 1 for 16, 2 for 32, 3 unsupported |
| lane_mask | input | 16 | Byte write enables, bit i for byte i |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| dst_old | input | 128 | Current destination value |
| dst_new | output | 128 | Merged destination, registered |
| advance | output | 1 | One-cycle request to step predication state |

## Verification
A stimulus table covers each operation family with data built to separate the families. It includes carries that would cross an element boundary at the wrong width and sign patterns that tell counting leading zeros apart from counting leading sign bits. A sweep then pairs every opcode with every size under random operands and random masks, so any confusion between a byte and an element shows up as a wrong byte. Directed cases pin down exact values: the wrap of the absolute value, the all-zero counts, a partly written 32-bit word, a full 64-bit reversal, and the illegal codes whose output must equal the old destination.

// File: rtl/vec_lane_alu.sv
module vec_lane_alu #(
  parameter int VEC_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [4:0]            op,
  input  logic [1:0]            esize,
  input  logic [VEC_BITS/8-1:0] lane_mask,
  input  logic [VEC_BITS-1:0]   src_a,
  input  logic [VEC_BITS-1:0]   src_b,
  input  logic [VEC_BITS-1:0]   dst_old,
  output logic [VEC_BITS-1:0]   dst_new,
  output logic                  advance
);
  localparam int NB = VEC_BITS / 8;
  localparam logic [VEC_BITS-1:0] SIGN_H = {(VEC_BITS/16){16'h8000}};
  localparam logic [VEC_BITS-1:0] SIGN_S = {(VEC_BITS/32){32'h8000_0000}};

  localparam logic [4:0] OP_AND = 5'd0,  OP_ANDN = 5'd1,  OP_OR = 5'd2,   OP_ORN = 5'd3;
  localparam logic [4:0] OP_XOR = 5'd4,  OP_ADD = 5'd5,   OP_SUB = 5'd6,  OP_MUL = 5'd7;
  localparam logic [4:0] OP_ABS = 5'd8,  OP_NEG = 5'd9,   OP_CLZ = 5'd10, OP_CLS = 5'd11;
  localparam logic [4:0] OP_RB16 = 5'd12, OP_RB32 = 5'd13, OP_RH32 = 5'd14;
  localparam logic [4:0] OP_RB64 = 5'd15, OP_RH64 = 5'd16, OP_RW64 = 5'd17;
  localparam logic [4:0] OP_FABSH = 5'd18, OP_FABSS = 5'd19, OP_FNEGH = 5'd20, OP_FNEGS = 5'd21;
  localparam logic [4:0] OP_NOT = 5'd22;

  // leading zeros of a 33-bit value that always carries a stop bit
  function automatic logic [5:0] lead0(input logic [32:0] v);
    lead0 = 6'd33;
    for (int i = 0; i < 33; i++)
      if (v[i]) lead0 = 6'(32 - i);
  endfunction

  for (genvar s = 0; s < 3; s++) begin : g_sz
    localparam int W = 8 << s;
    logic [VEC_BITS-1:0] vec;
    for (genvar e = 0; e < VEC_BITS / W; e++) begin : g_el
      logic [W-1:0] a, b, r, sgn;
      logic [32:0]  za, zs;
      assign a   = src_a[e*W +: W];
      assign b   = src_b[e*W +: W];
      assign sgn = a ^ {a[W-1], a[W-1:1]};
      assign za  = 33'({a, 1'b1}) << (32 - W);
      assign zs  = 33'({sgn, 1'b1}) << (32 - W);
      always_comb begin
        case (op)
          OP_ADD:  r = a + b;
          OP_SUB:  r = a - b;
          OP_MUL:  r = a * b;
          OP_ABS:  r = a[W-1] ? -a : a;
          OP_NEG:  r = -a;
          OP_CLZ:  r = W'(lead0(za));
          OP_CLS:  r = W'(lead0(zs) - 6'd1);
          default: r = '0;
        endcase
      end
      assign vec[e*W +: W] = r;
    end
  end

  logic [2:0]          swz;
  logic [VEC_BITS-1:0] perm, res, merged;

  always_comb begin
    case (op)
      OP_RB16: swz = 3'd1;
      OP_RB32: swz = 3'd3;
      OP_RH32: swz = 3'd2;
      OP_RB64: swz = 3'd7;
      OP_RH64: swz = 3'd6;
      OP_RW64: swz = 3'd4;
      default: swz = 3'd0;
    endcase
  end

  always_comb
    for (int i = 0; i < NB; i++)
      perm[i*8 +: 8] = src_a[(i ^ int'(swz))*8 +: 8];

  always_comb begin
    res = dst_old;
    case (op)
      OP_AND:   res = src_a & src_b;
      OP_ANDN:  res = src_a & ~src_b;
      OP_OR:    res = src_a | src_b;
      OP_ORN:   res = src_a | ~src_b;
      OP_XOR:   res = src_a ^ src_b;
      OP_NOT:   res = ~src_a;
      OP_FABSH: res = src_a & ~SIGN_H;
      OP_FABSS: res = src_a & ~SIGN_S;
      OP_FNEGH: res = src_a ^ SIGN_H;
      OP_FNEGS: res = src_a ^ SIGN_S;
      OP_RB16, OP_RB32, OP_RH32, OP_RB64, OP_RH64, OP_RW64: res = perm;
      OP_ADD, OP_SUB, OP_MUL, OP_ABS, OP_NEG, OP_CLZ, OP_CLS:
        case (esize)
          2'd0:    res = g_sz[0].vec;
          2'd1:    res = g_sz[1].vec;
          2'd2:    res = g_sz[2].vec;
          default: res = dst_old;
        endcase
      default:  res = dst_old;
    endcase
  end

  always_comb
    for (int i = 0; i < NB; i++)
      merged[i*8 +: 8] = lane_mask[i] ? res[i*8 +: 8] : dst_old[i*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_new <= '0;
      advance <= 1'b0;
    end else begin
      advance <= in_valid;
      if (in_valid) dst_new <= merged;
    end
  end
endmodule

// File: rtl/vec_lane_alu_chk.sv
module vec_lane_alu_chk #(
  parameter int VEC_BITS = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [4:0]            op,
  input logic [1:0]            esize,
  input logic [VEC_BITS/8-1:0] lane_mask,
  input logic [VEC_BITS-1:0]   src_a,
  input logic [VEC_BITS-1:0]   src_b,
  input logic [VEC_BITS-1:0]   dst_old,
  input logic [VEC_BITS-1:0]   dst_new,
  input logic                  advance
);
  logic [VEC_BITS-1:0] keep;
  logic                bad;

  always_comb
    for (int i = 0; i < VEC_BITS / 8; i++)
      keep[i*8 +: 8] = {8{~lane_mask[i]}};

  assign bad = (op > 5'd22) || (op >= 5'd5 && op <= 5'd11 && esize == 2'd3);

  assert_masked_bytes_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((dst_new ^ $past(dst_old)) & $past(keep)) == '0);

  assert_advance_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> advance);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!advance && $stable(dst_new)));

  assert_xor_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd4 && &lane_mask) |=> dst_new == $past(src_a ^ src_b));

  assert_fneg_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd20 && &lane_mask) |=>
      (dst_new ^ $past(src_a)) == {(VEC_BITS/16){16'h8000}});

  assert_illegal_unchanged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bad) |=> dst_new == $past(dst_old));
endmodule

bind vec_lane_alu vec_lane_alu_chk #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
  .lane_mask(lane_mask), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
  .dst_new(dst_new), .advance(advance)
);

// File: tb/test_vec_lane_alu.sv
module test_vec_lane_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [4:0]   op = '0;
  logic [1:0]   esize = '0;
  logic [15:0]  lane_mask = '0;
  logic [127:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [127:0] dst_new;
  logic         advance;
  int           n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  vec_lane_alu i_vec_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
    .lane_mask(lane_mask), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .dst_new(dst_new), .advance(advance)
  );

  // op, esize, mask, a, b, old
  localparam logic [406:0] VECS [10] = '{
    {5'd5,  2'd0, 16'hFFFF, 128'h00FF_7F01_80FF_0102_0304_0506_0708_090A, 128'h0001_0101_80FF_FFFE_0101_0101_0101_0101, 128'h0},
    {5'd5,  2'd1, 16'hFFFF, 128'h00FF_7F01_80FF_0102_0304_0506_0708_090A, 128'h0001_0101_80FF_FFFE_0101_0101_0101_0101, 128'h0},
    {5'd6,  2'd2, 16'hF0F0, 128'h0000_0000_1234_5678_0000_0001_FFFF_FFFF, 128'h0000_0001_0000_0001_0000_0002_0000_0001, 128'hAAAA_AAAA_BBBB_BBBB_CCCC_CCCC_DDDD_DDDD},
    {5'd7,  2'd0, 16'h5A5A, 128'h1020_3040_5060_7080_90A0_B0C0_D0E0_F0FF, 128'h0203_0405_0607_0809_0A0B_0C0D_0E0F_1011, 128'h1111_2222_3333_4444_5555_6666_7777_8888},
    {5'd10, 2'd1, 16'hFFFF, 128'h0000_0001_0080_8000_7FFF_00FF_0100_0F00, 128'h0, 128'h0},
    {5'd11, 2'd1, 16'hFFFF, 128'h0000_0001_0080_8000_7FFF_FFFF_FF00_C000, 128'h0, 128'h0},
    {5'd8,  2'd2, 16'hFFFF, 128'h8000_0000_FFFF_FFFF_7FFF_FFFF_0000_0005, 128'h0, 128'h0},
    {5'd14, 2'd0, 16'h0FF0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 128'h0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {5'd1,  2'd3, 16'hFFFF, 128'hF0F0_F0F0_0F0F_0F0F_FFFF_0000_1234_5678, 128'hFF00_FF00_FF00_FF00_0000_FFFF_FFFF_0000, 128'h0},
    {5'd19, 2'd0, 16'hFFFF, 128'h8000_0000_7FFF_FFFF_8000_8000_0000_0001, 128'h0, 128'h0}
  };

  function automatic string req_of(input logic [4:0] o, input logic [1:0] s);
    if (o > 5'd22 || (o >= 5'd5 && o <= 5'd11 && s == 2'd3)) return "R9";
    if (o <= 5'd4 || o == 5'd22) return "R3";
    if (o <= 5'd7) return "R4";
    if (o <= 5'd9) return "R5";
    if (o <= 5'd11) return "R6";
    if (o <= 5'd17) return "R7";
    return "R8";
  endfunction

  function automatic logic [127:0] permute(input logic [127:0] a, input int c, input int u);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      int base = (i / c) * c;
      int off  = i % c;
      int src  = base + (c / u - 1 - off / u) * u + off % u;
      r[i*8 +: 8] = a[src*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_model(input logic [4:0] o, input logic [1:0] s,
      input logic [15:0] m, input logic [127:0] a, input logic [127:0] b, input logic [127:0] old);
    logic [127:0] r;
    r = old;
    case (o)
      5'd0:  r = a & b;
      5'd1:  r = a & ~b;
      5'd2:  r = a | b;
      5'd3:  r = a | ~b;
      5'd4:  r = a ^ b;
      5'd22: r = ~a;
      5'd12: r = permute(a, 2, 1);
      5'd13: r = permute(a, 4, 1);
      5'd14: r = permute(a, 4, 2);
      5'd15: r = permute(a, 8, 1);
      5'd16: r = permute(a, 8, 2);
      5'd17: r = permute(a, 8, 4);
      5'd18: r = a & ~{8{16'h8000}};
      5'd19: r = a & ~{4{32'h8000_0000}};
      5'd20: r = a ^ {8{16'h8000}};
      5'd21: r = a ^ {4{32'h8000_0000}};
      default: if (o <= 5'd11 && s != 2'd3) begin
        int w = 8 << s;
        logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : (32'h1 << w) - 32'h1;
        r = '0;
        for (int e = 0; e < 128 / w; e++) begin
          logic [31:0] x, y, z;
          logic stop;
          x = 32'(a >> (e * w)) & wm;
          y = 32'(b >> (e * w)) & wm;
          z = '0;
          stop = 1'b0;
          case (o)
            5'd5: z = x + y;
            5'd6: z = x - y;
            5'd7: z = x * y;
            5'd8: z = x[w-1] ? (~x + 32'd1) : x;
            5'd9: z = ~x + 32'd1;
            5'd10: for (int k = w - 1; k >= 0; k--)
                     if (!stop && !x[k]) z++; else stop = 1'b1;
            default: for (int k = w - 2; k >= 0; k--)
                       if (!stop && x[k] == x[w-1]) z++; else stop = 1'b1;
          endcase
          r = r | (128'(z & wm) << (e * w));
        end
      end
    endcase
    for (int i = 0; i < 16; i++)
      if (!m[i]) r[i*8 +: 8] = old[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one request, then sample after the capturing edge
  task automatic apply(input logic [4:0] o, input logic [1:0] s, input logic [15:0] m,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] old);
    @(negedge clk);
    op = o; esize = s; lane_mask = m; src_a = a; src_b = b; dst_old = old;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", 128'(advance), 128'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", dst_new, 128'h0);
    check("R2", 128'(advance), 128'd0);
    rst_n = 1'b1;

    foreach (VECS[v]) begin
      logic [406:0] t = VECS[v];
      apply(t[406:402], t[401:400], t[399:384], t[383:256], t[255:128], t[127:0]);
      check(req_of(t[406:402], t[401:400]), dst_new,
            ref_model(t[406:402], t[401:400], t[399:384], t[383:256], t[255:128], t[127:0]));
    end

    // every opcode against every size, random data and masks (R1 merge in all)
    for (int o = 0; o < 32; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [127:0] a = {$urandom(), $urandom(), $urandom(), $urandom()};
        logic [127:0] b = {$urandom(), $urandom(), $urandom(), $urandom()};
        logic [127:0] d = {$urandom(), $urandom(), $urandom(), $urandom()};
        logic [15:0]  m = 16'($urandom());
        apply(5'(o), 2'(s), m, a, b, d);
        check(req_of(5'(o), 2'(s)), dst_new, ref_model(5'(o), 2'(s), m, a, b, d));
      end
    end

    apply(5'd8, 2'd0, 16'h0001, 128'h80, 128'h0, 128'h0);
    check("R5", dst_new, 128'h80);
    apply(5'd10, 2'd2, 16'hFFFF, 128'h0, 128'h0, 128'h0);
    check("R6", dst_new, {4{32'h20}});
    apply(5'd11, 2'd1, 16'h0003, 128'hFFFF, 128'h0, 128'h0);
    check("R6", dst_new, 128'h000F);
    apply(5'd11, 2'd0, 16'h0001, 128'h01, 128'h0, 128'h0);
    check("R6", dst_new, 128'h06);
    apply(5'd5, 2'd2, 16'h0003, 128'h1, 128'hFFFF_FFFF, 128'h1122_3344);
    check("R1", dst_new, 128'h1122_0000);
    apply(5'd15, 2'd0, 16'hFFFF, 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F, 128'h0, 128'h0);
    check("R7", dst_new, 128'h0706_0504_0302_0100_0F0E_0D0C_0B0A_0908);
    apply(5'd21, 2'd0, 16'hFFFF, 128'h0, 128'h0, 128'h0);
    check("R8", dst_new, {4{32'h8000_0000}});
    apply(5'd7, 2'd1, 16'hFFFF, 128'h00FF_0100, 128'h0003_0100, 128'h0);
    check("R4", dst_new, 128'h02FD_0000);
    apply(5'd22, 2'd3, 16'hFFFF, 128'h0, 128'h0, 128'h5);
    check("R3", dst_new, {128{1'b1}});
    apply(5'd31, 2'd0, 16'hFFFF, 128'h1234, 128'h5678, 128'hDEAD_BEEF);
    check("R9", dst_new, 128'hDEAD_BEEF);
    apply(5'd5, 2'd3, 16'hFFFF, 128'h1, 128'h1, 128'hCAFE);
    check("R9", dst_new, 128'hCAFE);

    @(negedge clk);
    src_a = '1; dst_old = '1; lane_mask = '1;
    repeat (3) @(negedge clk);
    check("R2", dst_new, 128'hCAFE);
    check("R2", 128'(advance), 128'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule